// File: doc/BRIEF.md
# I2C Register Control Port

This block is a bus slave for a two-wire serial control interface. It keeps a bank of sixteen byte-wide configuration registers, and its whole bank stays visible to the surrounding logic at all times. A bus master writes to the bank, or reads from it, by first sending a pointer byte. That byte selects a register and chooses whether the pointer advances after each data byte. With the pointer advancing, one transaction can fill or dump a run of consecutive registers. Without it, a transaction keeps hitting the same register.

The two bus lines are sampled into the system clock, so the bus may run with no fixed phase relation to any other clock in the chip. The data line uses an open-drain drive: the block only ever pulls the line low, by asserting an output enable. The two low bits of the slave address come from strap pins. One of those pins doubles as a chip-select for an alternative serial format. A high-to-low edge on it latches a sticky flag that marks the alternative format as chosen. From then on the two-wire engine stays off the bus.

Top module: `i2c_regport`

## Requirements
- R1: The 7-bit slave address, from MSB to LSB, is 1,0,0,1,1 followed by the level of `strap_a1_i` and then the level of `strap_a0_cs_i`. The first byte after a START carries this address in bits 7..1, and bit 0 is the direction, where 1 means read.
- R2: The block acknowledges a matching address byte and every byte it receives afterwards. It does so by holding `sda_oe` high through the ninth SCL pulse, and it raises `sda_oe` only while SCL is low.
- R3: After an address byte that does not match, the block gives no acknowledge. It then ignores all bus traffic and changes no register until the next START.
- R4: In a write, the first byte after the address is the pointer byte. Bit 7 enables auto-increment, bits 6..4 are ignored, and bits 3..0 select the register.
- R5: With auto-increment off, every data byte of a write goes to the register selected by the pointer. A read with auto-increment off returns that same register for every byte. Registers change only when a received data byte is written.
- R6: With auto-increment on, the pointer advances by one after each data byte written or read, and it wraps from 15 to 0.
- R7: After an acknowledged read address, the block sends the selected register MSB first. It continues with the next byte while the master acknowledges. After a master NACK it releases SDA and goes idle.
- R8: A falling edge on `strap_a0_cs_i` sets `spi_mode_o`. The flag stays set until reset, even if the pin later goes high again. While the flag is set, the block does not acknowledge and no register changes.
- R9: Reset clears all registers, the pointer and its increment flag, `spi_mode_o` and `sda_oe`. A strap level that is held during reset does not set `spi_mode_o`.
- R10: After a STOP, the block ignores clocked bytes until a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pull data line low when 1 |
| strap_a1_i | input | 1 | Address strap, slave address bit 1 |
| strap_a0_cs_i | input | 1 | Address strap bit 0, shared with the alternative-format chip-select |
| regs_o | output | NUM_REGS*8 | Register bank, register n in bits n*8+7..n*8 |
| spi_mode_o | output | 1 | Sticky flag: alternative format selected |

## Verification
The bench uses the default build: sixteen registers, two-stage synchronizers and the 10011 address prefix. With only 128 possible 7-bit addresses, the bench can try every one against a strap setting, and it tries each strap combination against the four addresses that share the prefix. Sixteen registers keep a whole-bank write, and a read that runs past register 15 and wraps, short enough to check every register after each transaction.

// File: rtl/i2c_regport_pkg.sv
package i2c_regport_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } bus_state_t;

endpackage

// File: rtl/i2c_regport_sync.sv
module i2c_regport_sync #(
  parameter int                WIDTH   = 4,
  parameter int                STAGES  = 2,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], d};
  end

  assign q = pipe[STAGES-1];

endmodule

// File: rtl/i2c_regport_events.sv
module i2c_regport_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  input  logic cs_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall,
  output logic spi_mode
);

  logic scl_q, sda_q, cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      cs_q     <= 1'b0;
      spi_mode <= 1'b0;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
      cs_q  <= cs_s;
      if (cs_q && !cs_s) spi_mode <= 1'b1;
    end
  end

  assign start_ev = scl_q && scl_s && sda_q && !sda_s;
  assign stop_ev  = scl_q && scl_s && !sda_q && sda_s;
  assign scl_rise = !scl_q && scl_s;
  assign scl_fall = scl_q && !scl_s;

endmodule

// File: rtl/i2c_regport_bank.sv
module i2c_regport_bank #(
  parameter int NUM_REGS = 16,
  parameter int PTR_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_addr,
  input  logic [7:0]            wr_data,
  input  logic [PTR_W-1:0]      rd_addr,
  output logic [7:0]            rd_data,
  output logic [NUM_REGS*8-1:0] regs_flat
);

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                    q <= '0;
      else if (wr_en && (wr_addr == PTR_W'(r)))   q <= wr_data;
    end
    assign regs_flat[r*8 +: 8] = q;
  end

  assign rd_data = regs_flat[{rd_addr, 3'b000} +: 8];

endmodule

// File: rtl/i2c_regport_ctrl.sv
module i2c_regport_ctrl
  import i2c_regport_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         PTR_W       = 4,
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_mode,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic [1:0]       dev_lo,
  input  logic [7:0]       rd_data,
  output logic             sda_oe,
  output logic             wr_en,
  output logic [PTR_W-1:0] wr_addr,
  output logic [7:0]       wr_data,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_REGS - 1);

  bus_state_t st;
  logic [7:0] sh;
  logic [2:0] cnt;
  logic       byte_done;
  logic       rw;
  logic       nack;
  logic       incr;
  logic [6:0] dev_addr;

  assign dev_addr = {ADDR_PREFIX, dev_lo};

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      sh        <= '0;
      cnt       <= '0;
      byte_done <= 1'b0;
      rw        <= 1'b0;
      nack      <= 1'b0;
      incr      <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (spi_mode) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        byte_done <= 1'b0;
      end else if (stop_ev) begin
        st        <= ST_IDLE;
        sda_oe    <= 1'b0;
        byte_done <= 1'b0;
      end else if (start_ev) begin
        st        <= ST_ADDR;
        sda_oe    <= 1'b0;
        cnt       <= '0;
        byte_done <= 1'b0;
      end else begin
        case (st)
          ST_ADDR, ST_PTR, ST_WDATA: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_s};
              cnt <= cnt + 3'd1;
              if (cnt == 3'd7) byte_done <= 1'b1;
            end else if (scl_fall && byte_done) begin
              byte_done <= 1'b0;
              if (st == ST_ADDR) begin
                if (sh[7:1] == dev_addr) begin
                  sda_oe <= 1'b1;
                  rw     <= sh[0];
                  st     <= ST_ADDR_ACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else if (st == ST_PTR) begin
                incr   <= sh[7];
                ptr    <= sh[PTR_W-1:0];
                sda_oe <= 1'b1;
                st     <= ST_PTR_ACK;
              end else begin
                wr_en   <= 1'b1;
                wr_addr <= ptr;
                wr_data <= sh;
                if (incr) ptr <= ptr_next(ptr);
                sda_oe  <= 1'b1;
                st      <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_RDATA;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_PTR;
              end
            end
          end
          ST_PTR_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              cnt    <= '0;
              st     <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                cnt    <= '0;
                st     <= ST_RACK;
                if (incr) ptr <= ptr_next(ptr);
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                cnt    <= cnt + 3'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              nack <= sda_s;
            end else if (scl_fall) begin
              if (nack) begin
                st <= ST_IDLE;
              end else begin
                sh     <= rd_data;
                sda_oe <= ~rd_data[7];
                st     <= ST_RDATA;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_regport.sv
module i2c_regport #(
  parameter int         NUM_REGS    = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [4:0] ADDR_PREFIX = 5'b10011
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  strap_a1_i,
  input  logic                  strap_a0_cs_i,
  output logic [NUM_REGS*8-1:0] regs_o,
  output logic                  spi_mode_o
);

  localparam int PTR_W = $clog2(NUM_REGS);

  logic [3:0]       pins_s;
  logic             scl_s, sda_s, cs_s, a1_s;
  logic             start_ev, stop_ev, scl_rise, scl_fall;
  logic             wr_en;
  logic [PTR_W-1:0] wr_addr, ptr;
  logic [7:0]       wr_data, rd_data;

  i2c_regport_sync #(
    .WIDTH   (4),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (4'b0011)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({strap_a1_i, strap_a0_cs_i, sda_i, scl_i}),
    .q   (pins_s)
  );

  assign scl_s = pins_s[0];
  assign sda_s = pins_s[1];
  assign cs_s  = pins_s[2];
  assign a1_s  = pins_s[3];

  i2c_regport_events u_events (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .cs_s     (cs_s),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .spi_mode (spi_mode_o)
  );

  i2c_regport_ctrl #(
    .NUM_REGS    (NUM_REGS),
    .PTR_W       (PTR_W),
    .ADDR_PREFIX (ADDR_PREFIX)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .spi_mode (spi_mode_o),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .sda_s    (sda_s),
    .dev_lo   ({a1_s, cs_s}),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .ptr      (ptr)
  );

  i2c_regport_bank #(
    .NUM_REGS (NUM_REGS),
    .PTR_W    (PTR_W)
  ) u_bank (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (ptr),
    .rd_data   (rd_data),
    .regs_flat (regs_o)
  );

endmodule

// File: rtl/i2c_regport_chk.sv
module i2c_regport_chk #(
  parameter int NUM_REGS = 16
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  sda_oe,
  input logic                  spi_mode,
  input logic                  scl_s,
  input logic                  wr_en,
  input logic [NUM_REGS*8-1:0] regs
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (regs == '0 && !sda_oe && !spi_mode)); // R9

  AST_SPI_STICKY: assert property (@(posedge clk) disable iff (rst)
    spi_mode |=> spi_mode); // R8

  AST_SPI_SILENT: assert property (@(posedge clk) disable iff (rst)
    (spi_mode && $past(spi_mode)) |-> !sda_oe); // R8

  AST_REGS_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !$stable(regs) |-> $past(wr_en)); // R5

  AST_ACK_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !$past(scl_s)); // R2

endmodule

bind i2c_regport i2c_regport_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .spi_mode (spi_mode_o),
  .scl_s    (scl_s),
  .wr_en    (wr_en),
  .regs     (regs_o)
);

// File: tb/test_i2c_regport.sv
`timescale 1ns/1ps
module test_i2c_regport;

  localparam int NREG = 16;
  localparam int Q    = 10;
  localparam int H    = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic a1 = 1'b0;
  logic cs = 1'b0;
  logic sda_oe;
  logic spi_mode_o;
  logic [NREG*8-1:0] regs_o;
  wire  sda_line;

  assign sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  i2c_regport #(.NUM_REGS(NREG)) i_i2c_regport (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_m),
    .sda_i         (sda_line),
    .sda_oe        (sda_oe),
    .strap_a1_i    (a1),
    .strap_a0_cs_i (cs),
    .regs_o        (regs_o),
    .spi_mode_o    (spi_mode_o)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [7:0] exp_r [NREG];
  logic [6:0] dev;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int reg_at(input int i);
    return int'(regs_o[i*8 +: 8]);
  endfunction

  task automatic check_all(input string req);
    for (int i = 0; i < NREG; i++) chk(req, reg_at(i), int'(exp_r[i]));
  endtask

  task automatic do_reset(input logic a1v, input logic csv);
    rst = 1'b1;
    wt(1);
    a1 = a1v; cs = csv; scl_m = 1'b1; sda_m = 1'b1;
    wt(5);
    rst = 1'b0;
    wt(5);
    for (int i = 0; i < NREG; i++) exp_r[i] = 8'h00;
    dev = {5'b10011, a1v, csv};
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output int ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(H/2);
    ack = sda_line ? 0 : 1;
    wt(H/2); scl_m = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl_m = 1'b1; wt(H/2); b[i] = sda_line; wt(H/2); scl_m = 1'b0; wt(Q);
    end
    sda_m = mack ? 1'b0 : 1'b1;
    wt(Q); scl_m = 1'b1; wt(H); scl_m = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_seq(input logic [7:0] pb, input int n, input int seed, input string req);
    int ack;
    int mp;
    int d;
    bus_start;
    send_byte({dev, 1'b0}, ack); chk("R2 addr ack", ack, 1);
    send_byte(pb, ack);          chk("R4 ptr ack", ack, 1);
    mp = int'(pb[3:0]);
    for (int k = 0; k < n; k++) begin
      d = (seed * 29 + k * 53 + 7) & 255;
      send_byte(d[7:0], ack);    chk("R2 data ack", ack, 1);
      exp_r[mp] = d[7:0];
      if (pb[7]) mp = (mp + 1) % NREG;
    end
    bus_stop;
    wt(4);
    check_all(req);
  endtask

  task automatic rd_seq(input logic [7:0] pb, input int n, input string req);
    int ack;
    int mp;
    logic [7:0] b;
    bus_start;
    send_byte({dev, 1'b0}, ack); chk("R2 addr ack", ack, 1);
    send_byte(pb, ack);          chk("R4 ptr ack", ack, 1);
    bus_stop;
    bus_start;
    send_byte({dev, 1'b1}, ack); chk("R7 read addr ack", ack, 1);
    mp = int'(pb[3:0]);
    for (int k = 0; k < n; k++) begin
      recv_byte(k != n - 1, b);
      chk(req, int'(b), int'(exp_r[mp]));
      if (pb[7]) mp = (mp + 1) % NREG;
    end
    wt(4);
    chk("R7 released after NACK", int'(sda_oe), 0);
    bus_stop;
  endtask

  initial begin : main
    int ack;
    // R9 reset state
    do_reset(1'b0, 1'b0);
    check_all("R9 regs");
    chk("R9 spi", int'(spi_mode_o), 0);
    chk("R9 oe", int'(sda_oe), 0);

    // R1 full address sweep with straps 00
    for (int a = 0; a < 128; a++) begin
      bus_start;
      send_byte({a[6:0], 1'b0}, ack);
      chk("R1 sweep", ack, (a == 7'h4C) ? 1 : 0);
      bus_stop;
    end
    check_all("R3 no write during sweep");

    // R1 remaining strap settings
    for (int s = 1; s < 4; s++) begin
      do_reset(s[1], s[0]);
      for (int lo = 0; lo < 4; lo++) begin
        bus_start;
        send_byte({5'b10011, lo[1:0], 1'b0}, ack);
        chk("R1 strap", ack, (lo == s) ? 1 : 0);
        bus_stop;
      end
      chk("R9 strap held, no spi", int'(spi_mode_o), 0);
    end

    do_reset(1'b0, 1'b0);
    wr_seq(8'h75, 3, 1, "R4 reserved bits ignored");
    wr_seq(8'h03, 3, 2, "R5 same register");
    wr_seq(8'h8E, 4, 3, "R6 write wrap");
    wr_seq(8'h80, 16, 4, "R6 block write");

    rd_seq(8'h80, 17, "R6 block read wrap");
    rd_seq(8'h06, 3, "R5 read same register");
    rd_seq(8'h8D, 4, "R7 read data");

    // R3 mismatch then data bytes ignored
    bus_start;
    send_byte({7'h4D, 1'b0}, ack); chk("R3 mismatch nack", ack, 0);
    send_byte(8'h82, ack);         chk("R3 ignored byte", ack, 0);
    send_byte(8'h5A, ack);         chk("R3 ignored byte", ack, 0);
    bus_stop;
    wt(4);
    check_all("R3 regs unchanged");

    // R10 bytes after STOP without START
    bus_start;
    send_byte({dev, 1'b0}, ack);   chk("R2 addr ack", ack, 1);
    send_byte(8'h81, ack);         chk("R4 ptr ack", ack, 1);
    bus_stop;
    send_byte(8'hA5, ack);         chk("R10 no ack after stop", ack, 0);
    send_byte(8'h3C, ack);         chk("R10 no ack after stop", ack, 0);
    wt(4);
    check_all("R10 regs unchanged");

    // R8 chip-select falling edge
    do_reset(1'b0, 1'b1);
    wr_seq(8'h02, 1, 5, "R1 strap a0 high write");
    chk("R8 no spi before edge", int'(spi_mode_o), 0);
    cs = 1'b0;
    wt(10);
    chk("R8 spi latched", int'(spi_mode_o), 1);
    cs = 1'b1;
    wt(10);
    chk("R8 spi sticky", int'(spi_mode_o), 1);
    bus_start;
    send_byte({dev, 1'b0}, ack);   chk("R8 no ack in spi", ack, 0);
    send_byte(8'h02, ack);         chk("R8 no ack in spi", ack, 0);
    send_byte(8'hEE, ack);         chk("R8 no ack in spi", ack, 0);
    bus_stop;
    wt(4);
    check_all("R8 regs unchanged");
    do_reset(1'b0, 1'b1);
    chk("R9 reset clears spi", int'(spi_mode_o), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule